// File: doc/BRIEF.md
# Line Blanking and Burst Gate Timer

This block produces two timing pulses for a video line. A blanking pulse appears on every line, and a burst gate pulse appears only on a window of lines counted from the last vertical reset. Both pulses are timed from the rising edge of the separated horizontal sync. The block runs on a clock locked to the line rate: 910 clocks per line for NTSC and 282 clocks per line for PAL. A single-cycle strobe marks each horizontal sync edge. A second strobe marks the vertical reset. A level input selects the standard.

All durations are held as clock counts, and each count is chosen from the selected standard. For NTSC the blanking pulse lasts 127 clocks, and the burst gate starts 76 clocks after blanking starts and lasts 36 clocks. For PAL the blanking pulse lasts 39 clocks, and the burst gate starts 25 clocks after blanking starts and lasts 10 clocks. A line counter enables the burst gate. It restarts at the vertical reset and saturates, so the gate cannot wrap back into the window.

Top module: `line_pulse_gen`

## Requirements
- R1: After reset, `blank_o` and `burst_o` are low until the first `hedge_i` strobe. The line counter comes out of reset saturated, so no burst gate is produced until a `vreset_i` strobe has been seen.
- R2: In NTSC (`pal_i`=0), `blank_o` rises in the cycle after a `hedge_i` strobe is sampled and stays high for exactly 127 clocks.
- R3: `burst_o` rises 76 (NTSC) or 25 (PAL) clocks after `blank_o` rises, and stays high for exactly 36 (NTSC) or 10 (PAL) clocks.
- R4: A `vreset_i` strobe sets the line count to 0 and wins over a `hedge_i` strobe in the same cycle. Each other `hedge_i` adds one to the count. A line's number is the count after its own edge, so the first line after a vertical reset is line 1.
- R5: `burst_o` is produced only on lines 10 to 256 inclusive for NTSC and lines 10 to 304 inclusive for PAL. `blank_o` is produced on every line.
- R6: The line count saturates at 511 and never wraps back into the burst window.
- R7: A `hedge_i` strobe that arrives while a pulse is still running restarts both timings from zero. Blanking then lasts its full length from the new edge.
- R8: `pal_i`=1 selects the PAL counts, and `blank_o` then lasts 39 clocks per line. `pal_i` must be held steady within a line.
- R9: `burst_o` is never high while `blank_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hedge_i | input | 1 | One-cycle strobe at each rising edge of horizontal sync |
| vreset_i | input | 1 | One-cycle vertical reset strobe |
| pal_i | input | 1 | Standard select: 0 for NTSC, 1 for PAL |
| blank_o | output | 1 | Registered active-high blanking pulse |
| burst_o | output | 1 | Registered active-high burst gate pulse |

## Verification
The hardest state to reach is the saturated line count in PAL. It needs more than five hundred lines after a vertical reset with no further reset. The stimulus gets there by running shortened PAL lines, each just longer than the blanking span, through a full sweep past count 511. Before that sweep it places a vertical reset in the middle of the frame, which checks that the window restarts at line 1. In both standards, a deliberately short line is cut off by the next edge while blanking is still high, so that the restart of the timing is seen at the ports.

// File: rtl/line_pulse_pkg.sv
package line_pulse_pkg;

    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } vid_std_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/line_std_sel.sv
module line_std_sel
    import line_pulse_pkg::*;
#(
    parameter int unsigned POS_W     = 7,
    parameter int unsigned LINE_W    = 9,
    parameter int unsigned N_BLANK   = 127,
    parameter int unsigned N_BDLY    = 76,
    parameter int unsigned N_BWID    = 36,
    parameter int unsigned N_WLO     = 10,
    parameter int unsigned N_WHI     = 256,
    parameter int unsigned P_BLANK   = 39,
    parameter int unsigned P_BDLY    = 25,
    parameter int unsigned P_BWID    = 10,
    parameter int unsigned P_WLO     = 10,
    parameter int unsigned P_WHI     = 304
) (
    input  vid_std_e           std_i,
    output logic [POS_W-1:0]   blank_len_o,
    output logic [POS_W-1:0]   burst_dly_o,
    output logic [POS_W-1:0]   burst_wid_o,
    output logic [POS_W-1:0]   span_o,
    output logic [LINE_W-1:0]  win_lo_o,
    output logic [LINE_W-1:0]  win_hi_o
);

    localparam int unsigned N_SPAN = umax(N_BLANK, N_BDLY + N_BWID);
    localparam int unsigned P_SPAN = umax(P_BLANK, P_BDLY + P_BWID);

    always_comb begin
        if (std_i == STD_PAL) begin
            blank_len_o = POS_W'(P_BLANK);
            burst_dly_o = POS_W'(P_BDLY);
            burst_wid_o = POS_W'(P_BWID);
            span_o      = POS_W'(P_SPAN);
            win_lo_o    = LINE_W'(P_WLO);
            win_hi_o    = LINE_W'(P_WHI);
        end else begin
            blank_len_o = POS_W'(N_BLANK);
            burst_dly_o = POS_W'(N_BDLY);
            burst_wid_o = POS_W'(N_BWID);
            span_o      = POS_W'(N_SPAN);
            win_lo_o    = LINE_W'(N_WLO);
            win_hi_o    = LINE_W'(N_WHI);
        end
    end

endmodule

// File: rtl/line_window_ctr.sv
module line_window_ctr #(
    parameter int unsigned LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hedge_i,
    input  logic              vreset_i,
    input  logic [LINE_W-1:0] win_lo_i,
    input  logic [LINE_W-1:0] win_hi_i,
    output logic              gate_o
);

    localparam logic [LINE_W-1:0] LINE_SAT = '1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              gate;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vreset_i) begin
            st_d.line = '0;
        end else if (hedge_i && (st_q.line != LINE_SAT)) begin
            st_d.line = st_q.line + LINE_W'(1);
        end
        if (hedge_i) begin
            st_d.gate = (st_d.line >= win_lo_i) && (st_d.line <= win_hi_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= LINE_SAT;
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_d.gate;

endmodule

// File: rtl/line_pulse_timer.sv
module line_pulse_timer #(
    parameter int unsigned POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hedge_i,
    input  logic             gate_i,
    input  logic [POS_W-1:0] blank_len_i,
    input  logic [POS_W-1:0] burst_dly_i,
    input  logic [POS_W-1:0] burst_wid_i,
    input  logic [POS_W-1:0] span_i,
    output logic             blank_o,
    output logic             burst_o
);

    typedef struct packed {
        logic             act;
        logic [POS_W-1:0] pos;
        logic             blank;
        logic             burst;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic [POS_W:0] pos_inc;
    logic [POS_W:0] burst_end;

    always_comb begin
        st_d      = st_q;
        pos_inc   = {1'b0, st_q.pos} + (POS_W+1)'(1);
        burst_end = {1'b0, burst_dly_i} + {1'b0, burst_wid_i};
        if (hedge_i) begin
            st_d.act = 1'b1;
            st_d.pos = '0;
        end else if (st_q.act) begin
            if (pos_inc >= {1'b0, span_i}) begin
                st_d.act = 1'b0;
            end else begin
                st_d.pos = pos_inc[POS_W-1:0];
            end
        end
        st_d.blank = st_d.act && (st_d.pos < blank_len_i);
        st_d.burst = st_d.act && gate_i && (st_d.pos >= burst_dly_i)
                     && ({1'b0, st_d.pos} < burst_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blank_o = st_q.blank;
    assign burst_o = st_q.burst;

endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
    import line_pulse_pkg::*;
#(
    parameter int unsigned NTSC_BLANK = 127,
    parameter int unsigned NTSC_BDLY  = 76,
    parameter int unsigned NTSC_BWID  = 36,
    parameter int unsigned NTSC_WLO   = 10,
    parameter int unsigned NTSC_WHI   = 256,
    parameter int unsigned PAL_BLANK  = 39,
    parameter int unsigned PAL_BDLY   = 25,
    parameter int unsigned PAL_BWID   = 10,
    parameter int unsigned PAL_WLO    = 10,
    parameter int unsigned PAL_WHI    = 304
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hedge_i,
    input  logic vreset_i,
    input  logic pal_i,
    output logic blank_o,
    output logic burst_o
);

    localparam int unsigned SPAN_MAX = umax(umax(NTSC_BLANK, NTSC_BDLY + NTSC_BWID),
                                            umax(PAL_BLANK, PAL_BDLY + PAL_BWID));
    localparam int unsigned POS_W    = $clog2(SPAN_MAX + 1);
    localparam int unsigned LINE_W   = $clog2(umax(NTSC_WHI, PAL_WHI) + 2);

    vid_std_e          std_sel;
    logic [POS_W-1:0]  blank_len;
    logic [POS_W-1:0]  burst_dly;
    logic [POS_W-1:0]  burst_wid;
    logic [POS_W-1:0]  span;
    logic [LINE_W-1:0] win_lo;
    logic [LINE_W-1:0] win_hi;
    logic              gate;

    assign std_sel = vid_std_e'(pal_i);

    line_std_sel #(
        .POS_W   (POS_W),
        .LINE_W  (LINE_W),
        .N_BLANK (NTSC_BLANK),
        .N_BDLY  (NTSC_BDLY),
        .N_BWID  (NTSC_BWID),
        .N_WLO   (NTSC_WLO),
        .N_WHI   (NTSC_WHI),
        .P_BLANK (PAL_BLANK),
        .P_BDLY  (PAL_BDLY),
        .P_BWID  (PAL_BWID),
        .P_WLO   (PAL_WLO),
        .P_WHI   (PAL_WHI)
    ) sel_i (
        .std_i       (std_sel),
        .blank_len_o (blank_len),
        .burst_dly_o (burst_dly),
        .burst_wid_o (burst_wid),
        .span_o      (span),
        .win_lo_o    (win_lo),
        .win_hi_o    (win_hi)
    );

    line_window_ctr #(
        .LINE_W (LINE_W)
    ) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hedge_i  (hedge_i),
        .vreset_i (vreset_i),
        .win_lo_i (win_lo),
        .win_hi_i (win_hi),
        .gate_o   (gate)
    );

    line_pulse_timer #(
        .POS_W (POS_W)
    ) tmr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hedge_i     (hedge_i),
        .gate_i      (gate),
        .blank_len_i (blank_len),
        .burst_dly_i (burst_dly),
        .burst_wid_i (burst_wid),
        .span_i      (span),
        .blank_o     (blank_o),
        .burst_o     (burst_o)
    );

endmodule

// File: rtl/line_pulse_gen_chk.sv
module line_pulse_gen_chk #(
    parameter int unsigned MAX_WID = 36
) (
    input logic clk,
    input logic rst_n,
    input logic hedge_i,
    input logic blank_o,
    input logic burst_o
);

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (burst_o) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R2
    blank_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hedge_i |=> blank_o);

    // R7
    blank_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_o) |-> $past(hedge_i));

    // R9
    burst_inside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> blank_o);

    // R3
    burst_width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= MAX_WID);

endmodule

bind line_pulse_gen line_pulse_gen_chk #(
    .MAX_WID (line_pulse_pkg::umax(NTSC_BWID, PAL_BWID))
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hedge_i (hedge_i),
    .blank_o (blank_o),
    .burst_o (burst_o)
);

// File: tb/line_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module line_pulse_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hedge_i = 1'b0;
    logic vreset_i = 1'b0;
    logic pal_i = 1'b0;
    logic blank_o;
    logic burst_o;

    int n_chk = 0;
    int n_fail = 0;
    int exp_line = 511;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_pulse_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hedge_i  (hedge_i),
        .vreset_i (vreset_i),
        .pal_i    (pal_i),
        .blank_o  (blank_o),
        .burst_o  (burst_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic run_line(input int len, input bit vr, input string tag_ovr);
        int bl, dly, wid, whi, bad_b, bad_g, bad_c, fj_b, fj_g;
        bit gate, eb, eg, ab_b, ag_g;
        string tb_, tg_;
        bl  = pal_i ? 39 : 127;
        dly = pal_i ? 25 : 76;
        wid = pal_i ? 10 : 36;
        whi = pal_i ? 304 : 256;
        @(negedge clk);
        hedge_i  = 1'b1;
        vreset_i = vr;
        if (vr) exp_line = 0;
        else if (exp_line < 511) exp_line++;
        gate = (exp_line >= 10) && (exp_line <= whi);
        bad_b = 0; bad_g = 0; bad_c = 0; fj_b = -1; fj_g = -1;
        ab_b = 1'b0; ag_g = 1'b0;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (j == 0) begin
                hedge_i  = 1'b0;
                vreset_i = 1'b0;
            end
            eb = (j < bl);
            eg = gate && (j >= dly) && (j < dly + wid);
            if (blank_o !== eb) begin
                if (bad_b == 0) begin fj_b = j; ab_b = blank_o; end
                bad_b++;
            end
            if (burst_o !== eg) begin
                if (bad_g == 0) begin fj_g = j; ag_g = burst_o; end
                bad_g++;
            end
            if (burst_o && !blank_o) bad_c++;
        end
        if (tag_ovr != "") begin
            tb_ = tag_ovr;
            tg_ = tag_ovr;
        end else begin
            tb_ = pal_i ? "R8" : "R2";
            if (exp_line == 511) tg_ = "R6";
            else if (gate) tg_ = "R3";
            else tg_ = "R5";
        end
        chk(bad_b == 0, tb_, $sformatf("blank line %0d offset %0d", exp_line, fj_b),
            int'(ab_b), int'(!ab_b));
        chk(bad_g == 0, tg_, $sformatf("burst line %0d offset %0d", exp_line, fj_g),
            int'(ag_g), int'(!ag_g));
        chk(bad_c == 0, "R9", "burst cycles outside blank", bad_c, 0);
    endtask

    initial begin
        int bad_r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        bad_r = 0;
        repeat (20) begin
            @(negedge clk);
            if (blank_o !== 1'b0 || burst_o !== 1'b0) bad_r++;
        end
        chk(bad_r == 0, "R1", "outputs high before first edge", bad_r, 0);

        // R1: no burst before any vertical reset
        for (int i = 0; i < 12; i++) run_line(130, 1'b0, "R1");

        // NTSC frame, R4 on the reset line
        run_line(130, 1'b1, "R4");
        for (int i = 1; i < 300; i++) begin
            if (i == 50) begin
                run_line(20, 1'b0, "R7");
                run_line(130, 1'b0, "R7");
                i++;
            end else begin
                run_line(130, 1'b0, "");
            end
        end

        // PAL: R8, mid-frame vertical reset, then saturation sweep (R6)
        pal_i = 1'b1;
        run_line(45, 1'b1, "R4");
        for (int i = 1; i < 200; i++) begin
            if (i == 20) begin
                run_line(12, 1'b0, "R7");
                run_line(45, 1'b0, "R7");
                i++;
            end else begin
                run_line(45, 1'b0, "");
            end
        end
        run_line(45, 1'b1, "R4");
        for (int i = 1; i < 520; i++) run_line(45, 1'b0, "");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule